// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between one processor port and its cache controller and keeps a record of every memory request still in flight. Each request is keyed by its cache-line address, which is the request address with the byte-offset bits dropped. The request kind decides which of two tables receives it. Reads and fetches go to one table. Stores, atomic halves and reservation accesses go to the other.

A request is admitted in the same cycle it is presented, and only if all three admission conditions hold. The combined occupancy must be below the configured ceiling. No entry in either table may already hold the same line. The access must not run past the end of its line. When the cache reports a completion for a line in a named table, the block frees the entry. It then reports the original request id and the number of cycles the request was pending.

A periodic age check starts when the first request enters an idle tracker. It repeats every threshold cycles while anything is pending, and it latches a fatal deadlock flag once any entry has been pending for at least the threshold.

Top module: `req_tracker`

## Requirements
- R1: Kinds 2 (store), 3 (atomic read half), 4 (atomic write half), 5 (reservation read) and 6 (reservation write) enter the write table. Kinds 0 (load), 1 (fetch) and 7 enter the read table. A completion only frees an entry in the table it names (`cpl_write`=1 for the write table).
- R2: `req_accept` is 0 when the number of pending entries, after any same-cycle release, is already `MAX_OUT`.
- R3: `req_accept` is 0 when either table holds a pending entry for the same line, which is `req_addr[ADDR_W-1:OFF_W]`.
- R4: `req_accept` is 0 when the byte offset `req_addr[OFF_W-1:0]` plus `req_len` exceeds `2**OFF_W`. A sum exactly equal to the line size is allowed.
- R5: `req_accept` is combinational in the request cycle. A completion in the same cycle is applied first, so both its freed slot and its line become available to that request.
- R6: A completion that finds its line raises `done_valid` for one cycle on the next cycle. In that cycle `done_id` carries the request id and `done_latency` carries the completion cycle minus the acceptance cycle.
- R7: A completion whose line is absent from the named table produces no `done_valid` and changes no entry.
- R8: Inserting into an idle tracker arms an age check that fires every `DL_THRESH` cycles and disarms once the tracker is empty. The check looks at entries present at the start of its cycle. If any of them has an age of at least `DL_THRESH` cycles, `deadlock` is set on the next cycle and stays set until reset.
- R9: After reset nothing is pending, and `done_valid` and `deadlock` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New request present |
| req_addr | input | ADDR_W | Byte address of request |
| req_kind | input | 3 | Request kind code (see R1) |
| req_id | input | ID_W | Request identifier |
| req_len | input | OFF_W+1 | Access length in bytes |
| req_accept | output | 1 | Request admitted this cycle |
| cpl_valid | input | 1 | Completion present |
| cpl_write | input | 1 | Completion targets write table |
| cpl_line | input | ADDR_W-OFF_W | Line address being completed |
| done_valid | output | 1 | A pending request retired |
| done_id | output | ID_W | Id of retired request |
| done_latency | output | TS_W | Cycles the request was pending |
| deadlock | output | 1 | Sticky deadlock indication |

## Verification
A completion and a new request can land in the same cycle, and the admission decision must then already see the released entry. The bench provokes this in two ways. It fills the tracker to the ceiling and completes one line while presenting a different line. It also completes a line while presenting a new request to that very line. The behavioural model applies the release before judging admission, and it compares `req_accept` in that cycle and the retirement outputs in the cycle after.

// File: rtl/mrt_pkg.sv
package mrt_pkg;

    typedef enum logic [2:0] {
        RQ_LOAD    = 3'd0,
        RQ_FETCH   = 3'd1,
        RQ_STORE   = 3'd2,
        RQ_ATOM_RD = 3'd3,
        RQ_ATOM_WR = 3'd4,
        RQ_RSV_RD  = 3'd5,
        RQ_RSV_WR  = 3'd6,
        RQ_SPARE   = 3'd7
    } rq_kind_e;

    // Kinds that modify or reserve a line live in the write table.
    function automatic logic goes_to_wr(input logic [2:0] kind);
        return (kind >= 3'(RQ_STORE)) && (kind <= 3'(RQ_RSV_WR));
    endfunction

endpackage

// File: rtl/rt_table.sv
module rt_table #(
    parameter int DEPTH  = 4,
    parameter int LINE_W = 12,
    parameter int ID_W   = 8,
    parameter int TS_W   = 16,
    parameter int THRESH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TS_W-1:0]   now_i,
    input  logic [LINE_W-1:0] probe_line_i,
    output logic              probe_hit_o,
    input  logic              alloc_i,
    input  logic [LINE_W-1:0] alloc_line_i,
    input  logic [ID_W-1:0]   alloc_id_i,
    input  logic              rel_i,
    input  logic [LINE_W-1:0] rel_line_i,
    output logic              rel_hit_o,
    output logic [ID_W-1:0]   rel_id_o,
    output logic [TS_W-1:0]   rel_ts_o,
    output logic [$clog2(DEPTH+1)-1:0] occ_o,
    output logic              stale_o
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic              vld;
        logic [LINE_W-1:0] line;
        logic [ID_W-1:0]   id;
        logic [TS_W-1:0]   ts;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0] slot;
    } tbl_st_t;

    tbl_st_t st_q, st_d;

    logic [DEPTH-1:0] match_rel;
    logic [DEPTH-1:0] match_probe;
    logic [DEPTH-1:0] stale_vec;
    logic [DEPTH-1:0] vld_vec;
    logic [DEPTH-1:0] open_vec;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_ok;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [TS_W-1:0] age;
        assign vld_vec[i]     = st_q.slot[i].vld;
        assign match_rel[i]   = rel_i && st_q.slot[i].vld && (st_q.slot[i].line == rel_line_i);
        assign match_probe[i] = st_q.slot[i].vld && !match_rel[i] &&
                                (st_q.slot[i].line == probe_line_i);
        assign age            = now_i - st_q.slot[i].ts;
        assign stale_vec[i]   = st_q.slot[i].vld && (age >= TS_W'(THRESH));
        assign open_vec[i]    = !st_q.slot[i].vld || match_rel[i];
    end

    always_comb begin
        rel_id_o = '0;
        rel_ts_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match_rel[i]) begin
                rel_id_o = rel_id_o | st_q.slot[i].id;
                rel_ts_o = rel_ts_o | st_q.slot[i].ts;
            end
        end
        pick_idx = '0;
        pick_ok  = 1'b0;
        for (int i = DEPTH-1; i >= 0; i--) begin
            if (open_vec[i]) begin
                pick_idx = IDX_W'(i);
                pick_ok  = 1'b1;
            end
        end
    end

    assign rel_hit_o   = |match_rel;
    assign probe_hit_o = |match_probe;
    assign stale_o     = |stale_vec;
    assign occ_o       = OCC_W'($countones(vld_vec));

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (match_rel[i]) st_d.slot[i].vld = 1'b0;
        end
        if (alloc_i && pick_ok) begin
            st_d.slot[pick_idx].vld  = 1'b1;
            st_d.slot[pick_idx].line = alloc_line_i;
            st_d.slot[pick_idx].id   = alloc_id_i;
            st_d.slot[pick_idx].ts   = now_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_LINE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_rel)); // R3
    AST_ALLOC_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> pick_ok); // R2
endmodule

// File: rtl/rt_agecheck.sv
module rt_agecheck #(
    parameter int THRESH = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic insert_i,
    input  logic busy_next_i,
    input  logic stale_i,
    output logic dead_o
);
    localparam int TMR_W = (THRESH > 1) ? $clog2(THRESH) : 1;

    typedef struct packed {
        logic             armed;
        logic [TMR_W-1:0] tmr;
        logic             dead;
    } wd_st_t;

    wd_st_t st_q, st_d;
    logic   fire;

    assign fire = st_q.armed && (st_q.tmr == '0);

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.armed = busy_next_i;
            st_d.tmr   = TMR_W'(THRESH-1);
            if (stale_i) st_d.dead = 1'b1;
        end else if (insert_i && !st_q.armed) begin
            st_d.armed = 1'b1;
            st_d.tmr   = TMR_W'(THRESH-1);
        end else if (st_q.armed) begin
            st_d.tmr = st_q.tmr - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dead_o = st_q.dead;

    AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dead |=> st_q.dead); // R8
    AST_TMR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tmr <= TMR_W'(THRESH-1)); // R8
endmodule

// File: rtl/req_tracker.sv
module req_tracker
    import mrt_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int OFF_W     = 4,
    parameter int ID_W      = 8,
    parameter int MAX_OUT   = 4,
    parameter int TS_W      = 16,
    parameter int DL_THRESH = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [2:0]              req_kind,
    input  logic [ID_W-1:0]         req_id,
    input  logic [OFF_W:0]          req_len,
    output logic                    req_accept,
    input  logic                    cpl_valid,
    input  logic                    cpl_write,
    input  logic [ADDR_W-OFF_W-1:0] cpl_line,
    output logic                    done_valid,
    output logic [ID_W-1:0]         done_id,
    output logic [TS_W-1:0]         done_latency,
    output logic                    deadlock
);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int BLK    = 1 << OFF_W;
    localparam int CNT_W  = $clog2(MAX_OUT+1);
    localparam int SUM_W  = OFF_W + 2;

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [TS_W-1:0]  now;
        logic             done_v;
        logic [ID_W-1:0]  done_id;
        logic [TS_W-1:0]  done_lat;
    } top_st_t;

    top_st_t st_q, st_d;

    logic [LINE_W-1:0] req_line;
    logic [SUM_W-1:0]  span;
    logic              len_ok;
    logic              to_wr;
    logic              rd_rel, wr_rel;
    logic              rd_rel_hit, wr_rel_hit, cpl_hit;
    logic [ID_W-1:0]   rd_rel_id, wr_rel_id;
    logic [TS_W-1:0]   rd_rel_ts, wr_rel_ts;
    logic              rd_probe_hit, wr_probe_hit;
    logic              rd_alloc, wr_alloc;
    logic [CNT_W-1:0]  rd_occ, wr_occ;
    logic              rd_stale, wr_stale;
    logic [CNT_W-1:0]  cnt_after_rel;

    assign req_line = req_addr[ADDR_W-1:OFF_W];
    assign span     = SUM_W'(req_addr[OFF_W-1:0]) + SUM_W'(req_len);
    assign len_ok   = span <= SUM_W'(BLK);
    assign to_wr    = goes_to_wr(req_kind);

    assign rd_rel  = cpl_valid && !cpl_write;
    assign wr_rel  = cpl_valid &&  cpl_write;
    assign cpl_hit = rd_rel_hit || wr_rel_hit;

    assign cnt_after_rel = st_q.count - CNT_W'(cpl_hit);

    assign req_accept = req_valid && len_ok && (cnt_after_rel < CNT_W'(MAX_OUT)) &&
                        !rd_probe_hit && !wr_probe_hit;
    assign rd_alloc   = req_accept && !to_wr;
    assign wr_alloc   = req_accept &&  to_wr;

    rt_table #(
        .DEPTH(MAX_OUT), .LINE_W(LINE_W), .ID_W(ID_W), .TS_W(TS_W), .THRESH(DL_THRESH)
    ) u_rd_tbl (
        .clk(clk), .rst_n(rst_n), .now_i(st_q.now),
        .probe_line_i(req_line), .probe_hit_o(rd_probe_hit),
        .alloc_i(rd_alloc), .alloc_line_i(req_line), .alloc_id_i(req_id),
        .rel_i(rd_rel), .rel_line_i(cpl_line), .rel_hit_o(rd_rel_hit),
        .rel_id_o(rd_rel_id), .rel_ts_o(rd_rel_ts),
        .occ_o(rd_occ), .stale_o(rd_stale)
    );

    rt_table #(
        .DEPTH(MAX_OUT), .LINE_W(LINE_W), .ID_W(ID_W), .TS_W(TS_W), .THRESH(DL_THRESH)
    ) u_wr_tbl (
        .clk(clk), .rst_n(rst_n), .now_i(st_q.now),
        .probe_line_i(req_line), .probe_hit_o(wr_probe_hit),
        .alloc_i(wr_alloc), .alloc_line_i(req_line), .alloc_id_i(req_id),
        .rel_i(wr_rel), .rel_line_i(cpl_line), .rel_hit_o(wr_rel_hit),
        .rel_id_o(wr_rel_id), .rel_ts_o(wr_rel_ts),
        .occ_o(wr_occ), .stale_o(wr_stale)
    );

    always_comb begin
        st_d        = st_q;
        st_d.now    = st_q.now + 1'b1;
        st_d.count  = cnt_after_rel + CNT_W'(req_accept);
        st_d.done_v = cpl_hit;
        if (rd_rel_hit) begin
            st_d.done_id  = rd_rel_id;
            st_d.done_lat = st_q.now - rd_rel_ts;
        end else if (wr_rel_hit) begin
            st_d.done_id  = wr_rel_id;
            st_d.done_lat = st_q.now - wr_rel_ts;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rt_agecheck #(.THRESH(DL_THRESH)) u_age (
        .clk(clk), .rst_n(rst_n),
        .insert_i(req_accept),
        .busy_next_i(st_d.count != '0),
        .stale_i(rd_stale || wr_stale),
        .dead_o(deadlock)
    );

    assign done_valid   = st_q.done_v;
    assign done_id      = st_q.done_id;
    assign done_latency = st_q.done_lat;

    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (CNT_W+1)'(st_q.count) == (CNT_W+1)'(rd_occ) + (CNT_W+1)'(wr_occ)); // R2
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(MAX_OUT)); // R2
    AST_DONE_AFTER_CPL: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(cpl_valid)); // R6
    AST_ONE_TABLE_FREED: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_rel_hit && wr_rel_hit)); // R1
    AST_ACCEPT_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        req_accept |=> (st_q.count != '0)); // R5
endmodule

// File: tb/req_tracker_tb.sv
module req_tracker_tb;
    localparam int ADDR_W = 16, OFF_W = 4, ID_W = 8, MAXO = 4, TS_W = 16, TH = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [2:0] req_kind = '0;
    logic [ID_W-1:0] req_id = '0;
    logic [OFF_W:0] req_len = '0;
    logic req_accept;
    logic cpl_valid = 1'b0;
    logic cpl_write = 1'b0;
    logic [ADDR_W-OFF_W-1:0] cpl_line = '0;
    logic done_valid;
    logic [ID_W-1:0] done_id;
    logic [TS_W-1:0] done_latency;
    logic deadlock;

    req_tracker #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ID_W(ID_W), .MAX_OUT(MAXO),
                  .TS_W(TS_W), .DL_THRESH(TH)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_kind(req_kind), .req_id(req_id), .req_len(req_len), .req_accept(req_accept),
        .cpl_valid(cpl_valid), .cpl_write(cpl_write), .cpl_line(cpl_line),
        .done_valid(done_valid), .done_id(done_id), .done_latency(done_latency),
        .deadlock(deadlock));

    always #10 clk = ~clk;

    typedef struct { int line; int id; int ts; bit wr; } ent_s;
    ent_s mq[$];
    int cyc = 0;
    bit m_armed = 0;
    int m_due = 0;
    bit e_dead = 0;
    bit e_dv = 0;
    int e_did = 0, e_lat = 0;
    int total = 0, bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp, input string tag);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, tag, act, exp);
        end
    endtask

    function automatic bit kind_wr(input int k);
        return (k >= 2) && (k <= 6);
    endfunction

    task automatic step(input bit rv, input int addr, input int kind, input int id, input int len,
                        input bit cv, input bit cw, input int cline, input string rq, input string tag);
        int rel;
        int cnt_after;
        bit dup, lok, acc, fire, any_old;
        req_valid = rv; req_addr = ADDR_W'(addr); req_kind = 3'(kind);
        req_id = ID_W'(id); req_len = (OFF_W+1)'(len);
        cpl_valid = cv; cpl_write = cw; cpl_line = (ADDR_W-OFF_W)'(cline);
        #1;
        rel = -1;
        if (cv) foreach (mq[i]) if (mq[i].line == cline && mq[i].wr == cw) rel = i;
        cnt_after = mq.size() - ((rel >= 0) ? 1 : 0);
        dup = 0;
        foreach (mq[i]) if (i != rel && mq[i].line == (addr >> OFF_W)) dup = 1;
        lok = ((addr % 16) + len) <= 16;
        acc = rv && lok && (cnt_after < MAXO) && !dup;
        chk(req_accept == acc, rq, int'(req_accept), int'(acc), {tag, " accept"});
        @(posedge clk);
        fire = m_armed && (cyc == m_due);
        any_old = 0;
        foreach (mq[i]) if (cyc - mq[i].ts >= TH) any_old = 1;
        if (fire && any_old) e_dead = 1;
        e_dv = (rel >= 0);
        if (rel >= 0) begin
            e_did = mq[rel].id; e_lat = cyc - mq[rel].ts;
            mq.delete(rel);
        end
        if (acc) mq.push_back('{line: addr >> OFF_W, id: id, ts: cyc, wr: kind_wr(kind)});
        if (fire) begin
            if (mq.size() > 0) m_due = cyc + TH; else m_armed = 0;
        end else if (acc && !m_armed) begin
            m_armed = 1; m_due = cyc + TH;
        end
        cyc++;
        @(negedge clk);
        chk(done_valid == e_dv, rq, int'(done_valid), int'(e_dv), {tag, " done_valid"});
        if (e_dv) begin
            chk(int'(done_id) == e_did, rq, int'(done_id), e_did, {tag, " done_id"});
            chk(int'(done_latency) == e_lat, rq, int'(done_latency), e_lat, {tag, " latency"});
        end
        chk(deadlock == e_dead, rq, int'(deadlock), int'(e_dead), {tag, " deadlock"});
    endtask

    task automatic idle(input int n, input string rq);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, rq, "idle");
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(done_valid == 1'b0, "R9", int'(done_valid), 0, "reset done_valid");
        chk(deadlock == 1'b0, "R9", int'(deadlock), 0, "reset deadlock");
        chk(req_accept == 1'b0, "R9", int'(req_accept), 0, "reset accept");
        rst_n = 1'b1;

        // R1 R6: load into read table, completed 4 cycles later
        step(1, 16'h0100, 0, 1, 4, 0, 0, 0, "R1", "load");
        idle(3, "R6");
        step(0, 0, 0, 0, 0, 1, 0, 12'h010, "R6", "read cpl");
        idle(1, "R6");

        // R1 R7: store sits in write table; read completion misses it
        step(1, 16'h0200, 2, 2, 8, 0, 0, 0, "R1", "store");
        step(0, 0, 0, 0, 0, 1, 0, 12'h020, "R7", "wrong table cpl");
        step(0, 0, 0, 0, 0, 1, 1, 12'h0AA, "R7", "absent line cpl");
        step(0, 0, 0, 0, 0, 1, 1, 12'h020, "R1", "write cpl");

        // R2: fill to ceiling, next request refused
        step(1, 16'h0300, 0, 10, 4, 0, 0, 0, "R2", "fill0");
        step(1, 16'h0310, 3, 11, 4, 0, 0, 0, "R2", "fill1");
        step(1, 16'h0320, 1, 12, 4, 0, 0, 0, "R2", "fill2");
        step(1, 16'h0330, 5, 13, 4, 0, 0, 0, "R2", "fill3");
        step(1, 16'h0340, 0, 14, 4, 0, 0, 0, "R2", "over ceiling");
        // R5: same-cycle completion frees a slot
        step(1, 16'h0340, 0, 14, 4, 1, 0, 12'h030, "R5", "free slot same cycle");
        // R5: same-cycle completion frees the same line
        step(1, 16'h0314, 6, 15, 4, 1, 1, 12'h031, "R5", "same line readmit");
        step(0, 0, 0, 0, 0, 1, 0, 12'h032, "R6", "drain a");
        step(0, 0, 0, 0, 0, 1, 1, 12'h033, "R6", "drain b");
        step(0, 0, 0, 0, 0, 1, 0, 12'h034, "R6", "drain c");
        step(0, 0, 0, 0, 0, 1, 1, 12'h031, "R6", "drain d");

        // R3: same line refused in either table
        step(1, 16'h0400, 0, 20, 4, 0, 0, 0, "R3", "first");
        step(1, 16'h0408, 2, 21, 4, 0, 0, 0, "R3", "store same line");
        step(1, 16'h040C, 1, 22, 4, 0, 0, 0, "R3", "fetch same line");
        step(0, 0, 0, 0, 0, 1, 0, 12'h040, "R3", "drain");

        // R4: offset plus length
        step(1, 16'h050C, 0, 30, 8, 0, 0, 0, "R4", "past line end");
        step(1, 16'h050C, 7, 31, 4, 0, 0, 0, "R4", "exact line end");
        step(0, 0, 0, 0, 0, 1, 0, 12'h050, "R4", "drain");

        // R8: quiet tracker never flags
        idle(3 * TH, "R8");

        // R8: stuck request triggers sticky deadlock
        step(1, 16'h0600, 0, 40, 4, 0, 0, 0, "R8", "stuck");
        idle(2 * TH + 4, "R8");
        chk(deadlock == 1'b1, "R8", int'(deadlock), 1, "flag raised");
        step(0, 0, 0, 0, 0, 1, 0, 12'h060, "R8", "late cpl");
        idle(2, "R8");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule